// File: doc/BRIEF.md
# Sound Generator Bus Interface and Register File

This block is the processor-facing side of a three-voice sound generator. It holds the sixteen control registers that the tone, noise, mixer, level and envelope logic read, and it gives the processor access to them through a two-step protocol. First, an address cycle captures a register number into a latch. Then any number of write or read cycles act on that register.

The chip responds only when a fixed select pattern sits on the upper address lines. When the pattern does not match, the block never drives the data bus. Registers that hold fewer than eight bits store only their implemented bits, and they read back zero in the unimplemented positions. Every accepted write to the envelope shape register raises a single-cycle restart strobe toward the envelope generator.

The register contents are presented in parallel on a flat output bus for the sound blocks. The bidirectional data bus is split into an input, an output and an output enable, so a pad ring can build the tri-state driver.

Top module: `snd_bus_regs`

## Requirements
- R1: While rst_ni is low, and after it is released, every register reads 0, the address latch holds 0, data_oe_o is 0 and env_restart_o is 0.
- R2: The mode_i encoding is 00 idle, 01 read, 10 write and 11 address. An address cycle with addr_hi_i = 01 and data_i[7:4] = 0000 loads data_i[3:0] into the address latch at the clock edge.
- R3: An address cycle with addr_hi_i not equal to 01, or with data_i[7:4] nonzero, leaves the address latch unchanged.
- R4: A write cycle with addr_hi_i = 01 stores data_i into the latched register. The new value appears on regs_o (register n at bits 8n+7:8n) after that clock edge.
- R5: A read cycle with addr_hi_i = 01 sets data_oe_o and presents the latched register on data_o in the same cycle, combinationally. A read cycle changes no register.
- R6: data_oe_o is 0 in every cycle that is not a read cycle with addr_hi_i = 01.
- R7: Read, write and idle cycles do not change the address latch.
- R8: Registers 1, 3, 5 and 13 keep bits 3:0. Registers 6, 8, 9 and 10 keep bits 4:0. All other registers keep 8 bits. Unimplemented bits read 0 on both data_o and regs_o.
- R9: env_restart_o is 1 for exactly the one cycle after each accepted write to register 13, and 0 otherwise.
- R10: A write cycle with addr_hi_i not equal to 01 changes no register and raises no restart strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 2 | Bus cycle type: 00 idle, 01 read, 10 write, 11 address |
| addr_hi_i | input | 2 | Upper select lines; must equal 01 to select the chip |
| data_i | input | 8 | Data bus input: register number in address cycles, data in write cycles |
| data_o | output | 8 | Data bus output: the latched register's value during a selected read |
| data_oe_o | output | 1 | Drive enable for the data bus |
| regs_o | output | 128 | All sixteen registers in parallel, register n at bits 8n+7:8n |
| env_restart_o | output | 1 | One-cycle strobe after each accepted write to register 13 |

## Verification
The assertions assume that mode_i and addr_hi_i are stable around the clock edge and that mode_i is a 2-bit code, so all four values are legal. The stimulus changes inputs only on the falling edge. It mixes matching and non-matching select patterns in every mode, including address cycles whose upper data nibble is nonzero, and back-to-back writes to register 13. A reference model with per-register masks predicts data_o, data_oe_o, regs_o and env_restart_o. It is compared against the design in the middle of every cycle.

// File: rtl/snd_bus_pkg.sv
package snd_bus_pkg;

  localparam int unsigned SND_DW     = 8;
  localparam int unsigned SND_NREG   = 16;
  localparam int unsigned SND_RAW    = $clog2(SND_NREG);
  localparam int unsigned SND_SHAPE  = 13;

  typedef enum logic [1:0] {
    BUS_IDLE  = 2'b00,
    BUS_READ  = 2'b01,
    BUS_WRITE = 2'b10,
    BUS_ADDR  = 2'b11
  } bus_mode_e;

  // implemented-bit mask per register index
  function automatic logic [7:0] reg_mask(int unsigned idx);
    case (idx)
      1, 3, 5, 13:  reg_mask = 8'h0F;
      6, 8, 9, 10:  reg_mask = 8'h1F;
      default:      reg_mask = 8'hFF;
    endcase
  endfunction

endpackage

// File: rtl/snd_bus_decode.sv
module snd_bus_decode
  import snd_bus_pkg::*;
#(
  parameter int unsigned       HI_W     = 2,
  parameter logic [HI_W-1:0]   HI_MATCH = 2'b01,
  parameter int unsigned       DW       = SND_DW,
  parameter int unsigned       RAW      = SND_RAW
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [1:0]      mode_i,
  input  logic [HI_W-1:0] addr_hi_i,
  input  logic [DW-1:0]   data_i,
  output logic [RAW-1:0]  reg_sel_o,
  output logic            wr_en_o,
  output logic            rd_en_o
);

  localparam int unsigned UPW = DW - RAW;

  bus_mode_e mode;
  logic      hi_hit;
  logic      full_hit;
  logic      addr_load;

  assign mode      = bus_mode_e'(mode_i);
  assign hi_hit    = (addr_hi_i == HI_MATCH);
  // address cycles also require the upper data lines to be zero
  assign full_hit  = hi_hit && (data_i[DW-1:RAW] == UPW'(0));
  assign addr_load = (mode == BUS_ADDR) && full_hit;

  assign wr_en_o = (mode == BUS_WRITE) && hi_hit;
  assign rd_en_o = (mode == BUS_READ)  && hi_hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        reg_sel_o <= '0;
    else if (addr_load) reg_sel_o <= data_i[RAW-1:0];
  end

  p_latch_load_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'b11 && addr_hi_i == HI_MATCH && data_i[DW-1:RAW] == UPW'(0))
      |=> (reg_sel_o == $past(data_i[RAW-1:0])));

  p_miss_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'b11 && (addr_hi_i != HI_MATCH || data_i[DW-1:RAW] != UPW'(0)))
      |=> $stable(reg_sel_o));

  p_latch_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i != 2'b11) |=> $stable(reg_sel_o));

endmodule

// File: rtl/snd_reg_bank.sv
module snd_reg_bank
  import snd_bus_pkg::*;
#(
  parameter int unsigned DW        = SND_DW,
  parameter int unsigned NREG      = SND_NREG,
  parameter int unsigned RAW       = SND_RAW,
  parameter int unsigned SHAPE_IDX = SND_SHAPE
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic [RAW-1:0]     sel_i,
  input  logic [DW-1:0]      wdata_i,
  output logic [NREG*DW-1:0] regs_o,
  output logic               restart_o
);

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    localparam logic [DW-1:0] MASK = DW'(reg_mask(g));
    logic [DW-1:0] q;
    logic          hit;

    assign hit = wr_en_i && (sel_i == RAW'(g));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)  q <= '0;
      else if (hit) q <= wdata_i & MASK;
    end

    assign regs_o[g*DW +: DW] = q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) restart_o <= 1'b0;
    else         restart_o <= wr_en_i && (sel_i == RAW'(SHAPE_IDX));
  end

  p_restart_src_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_o |-> $past(wr_en_i && sel_i == RAW'(SHAPE_IDX)));

  p_no_write_stable_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(regs_o));

endmodule

// File: rtl/snd_read_mux.sv
module snd_read_mux #(
  parameter int unsigned DW   = 8,
  parameter int unsigned NREG = 16,
  parameter int unsigned RAW  = 4
) (
  input  logic               rd_en_i,
  input  logic [RAW-1:0]     sel_i,
  input  logic [NREG*DW-1:0] regs_i,
  output logic [DW-1:0]      data_o,
  output logic               oe_o
);

  logic [DW-1:0] pick;

  always_comb begin
    pick = '0;
    for (int i = 0; i < NREG; i++) begin
      if (sel_i == RAW'(i)) pick = regs_i[i*DW +: DW];
    end
  end

  assign oe_o   = rd_en_i;
  assign data_o = rd_en_i ? pick : '0;

endmodule

// File: rtl/snd_bus_regs.sv
module snd_bus_regs
  import snd_bus_pkg::*;
#(
  parameter int unsigned     HI_W      = 2,
  parameter logic [HI_W-1:0] HI_MATCH  = 2'b01,
  parameter int unsigned     DW        = SND_DW,
  parameter int unsigned     NREG      = SND_NREG,
  parameter int unsigned     SHAPE_IDX = SND_SHAPE
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [1:0]         mode_i,
  input  logic [HI_W-1:0]    addr_hi_i,
  input  logic [DW-1:0]      data_i,
  output logic [DW-1:0]      data_o,
  output logic               data_oe_o,
  output logic [NREG*DW-1:0] regs_o,
  output logic               env_restart_o
);

  localparam int unsigned RAW = $clog2(NREG);

  logic [RAW-1:0] reg_sel;
  logic           wr_en;
  logic           rd_en;

  snd_bus_decode #(
    .HI_W(HI_W), .HI_MATCH(HI_MATCH), .DW(DW), .RAW(RAW)
  ) i_decode (
    .clk_i, .rst_ni, .mode_i, .addr_hi_i, .data_i,
    .reg_sel_o(reg_sel), .wr_en_o(wr_en), .rd_en_o(rd_en)
  );

  snd_reg_bank #(
    .DW(DW), .NREG(NREG), .RAW(RAW), .SHAPE_IDX(SHAPE_IDX)
  ) i_bank (
    .clk_i, .rst_ni, .wr_en_i(wr_en), .sel_i(reg_sel), .wdata_i(data_i),
    .regs_o, .restart_o(env_restart_o)
  );

  snd_read_mux #(
    .DW(DW), .NREG(NREG), .RAW(RAW)
  ) i_rmux (
    .rd_en_i(rd_en), .sel_i(reg_sel), .regs_i(regs_o),
    .data_o, .oe_o(data_oe_o)
  );

  p_oe_only_read_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_oe_o |-> (mode_i == 2'b01 && addr_hi_i == HI_MATCH));

  p_miss_write_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_hi_i != HI_MATCH) |=> (!env_restart_o && $stable(regs_o)));

endmodule

// File: tb/test_snd_bus_regs.sv
`timescale 1ns/1ps
module test_snd_bus_regs;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [1:0]   mode = 2'b00;
  logic [1:0]   hi = 2'b01;
  logic [7:0]   din = 8'h00;
  logic [7:0]   dout;
  logic         oe;
  logic [127:0] regs;
  logic         restart;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [7:0] m_reg [16];
  logic [3:0] m_lat;
  logic       m_rst;

  always #2.5 clk = ~clk;

  snd_bus_regs i_snd_bus_regs (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode), .addr_hi_i(hi), .data_i(din),
    .data_o(dout), .data_oe_o(oe), .regs_o(regs), .env_restart_o(restart)
  );

  function automatic logic [7:0] bits_kept(int n);
    if (n == 1 || n == 3 || n == 5 || n == 13) return 8'h0F;
    if (n == 6 || n == 8 || n == 9 || n == 10) return 8'h1F;
    return 8'hFF;
  endfunction

  task automatic chk(string tag, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic compare_all();
    logic [127:0] flat;
    logic         e_oe;
    for (int n = 0; n < 16; n++) flat[n*8 +: 8] = m_reg[n];
    e_oe = (mode == 2'b01) && (hi == 2'b01);
    chk("R4/R8 regs_o", regs, flat);
    chk("R5/R6 data_oe_o", 128'(oe), 128'(e_oe));
    if (e_oe) chk("R5/R8 data_o", 128'(dout), 128'(m_reg[m_lat]));
    chk("R9 env_restart_o", 128'(restart), 128'(m_rst));
  endtask

  // one bus cycle: drive at negedge, compare mid-cycle, update model at posedge
  task automatic cyc(logic [1:0] md, logic [1:0] h, logic [7:0] d);
    @(negedge clk);
    mode = md; hi = h; din = d;
    #1;
    compare_all();
    @(posedge clk);
    m_rst = 1'b0;
    if (md == 2'b11 && h == 2'b01 && d[7:4] == 4'h0) m_lat = d[3:0];   // R2, R3
    if (md == 2'b10 && h == 2'b01) begin                               // R4, R10
      m_reg[m_lat] = d & bits_kept(int'(m_lat));
      m_rst = (m_lat == 4'd13);
    end
  endtask

  initial begin
    #400000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int n = 0; n < 16; n++) m_reg[n] = 8'h00;
    m_lat = 4'h0; m_rst = 1'b0;
    // R1: state held in reset
    repeat (3) @(negedge clk);
    chk("R1 regs_o in reset", regs, 128'h0);
    chk("R1 env_restart_o in reset", 128'(restart), 128'h0);
    chk("R1 data_oe_o in reset", 128'(oe), 128'h0);
    @(negedge clk); rst_n = 1'b1;
    cyc(2'b01, 2'b01, 8'h00);   // R1: read latch 0 after reset

    // R4/R8: fill every register with all-ones, read each back
    for (int n = 0; n < 16; n++) begin
      cyc(2'b11, 2'b01, 8'(n));
      cyc(2'b10, 2'b01, 8'hFF);
      cyc(2'b01, 2'b01, 8'h00);
    end
    // R7: latch survives read, write and idle; read again
    cyc(2'b00, 2'b01, 8'h03);
    cyc(2'b01, 2'b01, 8'h00);
    cyc(2'b10, 2'b01, 8'hA5);
    cyc(2'b01, 2'b01, 8'h00);

    // R3: mismatched address cycles leave the latch at 15
    cyc(2'b11, 2'b00, 8'h02);
    cyc(2'b11, 2'b10, 8'h02);
    cyc(2'b11, 2'b11, 8'h02);
    cyc(2'b11, 2'b01, 8'h12);
    cyc(2'b11, 2'b01, 8'hF2);
    cyc(2'b01, 2'b01, 8'h00);

    // R10: writes with wrong select change nothing; R6: reads with wrong select float
    cyc(2'b11, 2'b01, 8'h0D);
    cyc(2'b10, 2'b00, 8'h00);
    cyc(2'b10, 2'b11, 8'h00);
    cyc(2'b01, 2'b10, 8'h00);
    cyc(2'b01, 2'b01, 8'h00);

    // R9: back-to-back shape writes, then a gap
    cyc(2'b10, 2'b01, 8'h0E);
    cyc(2'b10, 2'b01, 8'h09);
    cyc(2'b00, 2'b01, 8'h00);
    cyc(2'b00, 2'b01, 8'h00);

    // mixed random traffic
    for (int k = 0; k < 3000; k++) begin
      logic [1:0] h;
      logic [7:0] d;
      h = ($urandom_range(0, 3) == 0) ? 2'($urandom) : 2'b01;
      d = ($urandom_range(0, 3) == 0) ? 8'($urandom) : {4'h0, 4'($urandom)};
      cyc(2'($urandom), h, d);
    end

    // R1: reset again clears everything
    @(negedge clk); rst_n = 1'b0; mode = 2'b00;
    for (int n = 0; n < 16; n++) m_reg[n] = 8'h00;
    m_lat = 4'h0; m_rst = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    cyc(2'b01, 2'b01, 8'h00);
    cyc(2'b00, 2'b01, 8'h00);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule